// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Generator

This block drives up to four interleaved PWM channels for a multi-phase buck regulator. All channels share one free-running period counter. The channels that are in use are spread evenly over one period. The combined output ripple therefore runs at the channel rate times the number of active phases.

The number of phases is not programmed. The block samples the levels of the two highest output pins once, right after reset is released. A board strapping an unused output high shortens the channel set.

Each active channel receives a common duty command, corrected by a balance term. The balance term is proportional to how far that channel's sampled current lies from the mean of the active channels. A channel that carries more than its share gets a narrower pulse, and one that carries less gets a wider pulse. The corrected duty saturates at both ends of its range.

Each channel also emits a one-cycle strobe that tells the external current sampler when to capture its current. The strobe comes one third of a period after that channel's on-time ends. A drive-enable output per channel marks when the pin is actively driven. When it is low, the pin is meant to float.

Top module: `ilv_pwm`

## Requirements
- R1: While `rst` is high, and after it, every output (`pwm_o`, `pwm_oe`, `samp_stb`) is 0 and `phases` is 0 until the phase count is latched.
- R2: On the first clock edge with `rst` low, the block latches the phase count from `strap_hi`, where bit 1 is the level of output 4 and bit 0 is the level of output 3. The code 2'b11 gives 2 phases, 2'b10 gives 3 phases and any other code gives 4 phases. The `phases` port reports 2, 3 or 4 from then on. All channel outputs stay 0 on that latching edge.
- R3: Changes on `strap_hi` after the phase count is latched have no effect on `phases` or on any channel until the next reset.
- R4: The period counter wraps modulo P = 2^CNT_W. It holds 0 in reset and advances on every edge. With n active phases, channel k starts at count k*floor(P/n). On each edge, `pwm_o[k]` is registered high when (cnt - start_k) mod P < duty_k, where cnt is the counter value before that edge.
- R5: Channels with index k >= n are inactive: their `pwm_oe`, `pwm_o` and `samp_stb` stay 0. At every edge with enable high, the number of set `pwm_oe` bits equals n.
- R6: duty_k = duty_cmd - ((i_k - avg) >>> BAL_SH). Here i_k is channel k's word in `isense` (bits k*I_W upward), avg = floor(sum of active i / n), and the shift is arithmetic, rounding toward minus infinity. The currents of inactive channels do not affect any duty.
- R7: The corrected duty saturates at 0 and at P-1; it never wraps.
- R8: `samp_stb[k]` is registered high for exactly one cycle per period, when (cnt - start_k) mod P equals (duty_k + floor(P/3)) mod P.
- R9: When `drive_en` is low, the next edge registers `pwm_oe`, `pwm_o` and `samp_stb` as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_hi | input | 2 | Sampled levels of outputs 4 (bit 1) and 3 (bit 0) |
| duty_cmd | input | CNT_W | Common duty command in counter ticks |
| isense | input | 4*I_W | Sampled channel currents, channel k at bits k*I_W upward |
| drive_en | input | 1 | Global drive enable; low floats all outputs |
| pwm_o | output | 4 | PWM level per channel |
| pwm_oe | output | 4 | Per-channel drive enable (0 = floating) |
| samp_stb | output | 4 | Per-channel current-sample strobe |
| phases | output | 3 | Latched active phase count (0 before latching) |

## Verification
On every cycle, the assertions check four things:
- Disable forces every output off on the next edge.
- The latched phase count is one of the legal values and never changes once set.
- The number of driven channels matches that count.

Pulse placement, balance arithmetic, saturation at both ends, strobe timing and the effect of straps only show in the bench scenarios. There, a behavioural model is compared with the outputs every cycle. In addition, measured pulse widths and strobe counts are checked against widths computed from the requirements, under varied straps and current patterns.

// File: rtl/ilv_pwm_pkg.sv
package ilv_pwm_pkg;
  localparam int NCH = 4;

  // bit1 = level of output 4, bit0 = level of output 3
  function automatic logic [2:0] strap_to_phases(input logic [1:0] s);
    case (s)
      2'b11:   return 3'd2;
      2'b10:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/phase_latch.sv
module phase_latch
  import ilv_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_hi,
  output logic [2:0] phases
);
  always_ff @(posedge clk) begin
    if (rst)              phases <= 3'd0;
    else if (phases == 0) phases <= strap_to_phases(strap_hi);
  end
endmodule

// File: rtl/duty_balance.sv
module duty_balance
  import ilv_pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int I_W    = 10,
  parameter int BAL_SH = 2
) (
  input  logic [2:0]           phases,
  input  logic [CNT_W-1:0]     duty_cmd,
  input  logic [NCH*I_W-1:0]   isense,
  output logic [NCH*CNT_W-1:0] duty_vec
);
  localparam int SUM_W = I_W + 2;
  localparam int DW    = CNT_W + I_W + 3;
  localparam logic [CNT_W-1:0] DMAX = {CNT_W{1'b1}};

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] avg;

  always_comb begin
    sum = '0;
    for (int k = 0; k < NCH; k++)
      if (k < int'(phases)) sum = sum + SUM_W'(isense[k*I_W +: I_W]);
    case (phases)
      3'd2:    avg = sum >> 1;
      3'd3:    avg = sum / SUM_W'(3);
      default: avg = sum >> 2;
    endcase
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic signed [I_W:0]  diff;
    logic signed [I_W:0]  off;
    logic signed [DW-1:0] val;
    always_comb begin
      diff = $signed({1'b0, isense[k*I_W +: I_W]}) - $signed({1'b0, avg[I_W-1:0]});
      off  = diff >>> BAL_SH;
      val  = $signed({{(DW-CNT_W){1'b0}}, duty_cmd}) - $signed({{(DW-I_W-1){off[I_W]}}, off});
      if (val < 0)
        duty_vec[k*CNT_W +: CNT_W] = '0;
      else if (val > $signed({{(DW-CNT_W){1'b0}}, DMAX}))
        duty_vec[k*CNT_W +: CNT_W] = DMAX;
      else
        duty_vec[k*CNT_W +: CNT_W] = val[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] duty,
  input  logic             active,
  output logic             pwm,
  output logic             oe,
  output logic             stb
);
  localparam int PER = 1 << CNT_W;
  localparam logic [CNT_W-1:0] THIRD = CNT_W'(PER / 3);

  logic [CNT_W-1:0] local_cnt;
  logic [CNT_W-1:0] stb_at;

  assign local_cnt = cnt - start;
  assign stb_at    = duty + THIRD;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm <= 1'b0;
      oe  <= 1'b0;
      stb <= 1'b0;
    end else begin
      oe  <= active;
      pwm <= active && (local_cnt < duty);
      stb <= active && (local_cnt == stb_at);
    end
  end
endmodule

// File: rtl/ilv_pwm.sv
module ilv_pwm
  import ilv_pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int I_W    = 10,
  parameter int BAL_SH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           strap_hi,
  input  logic [CNT_W-1:0]     duty_cmd,
  input  logic [NCH*I_W-1:0]   isense,
  input  logic                 drive_en,
  output logic [NCH-1:0]       pwm_o,
  output logic [NCH-1:0]       pwm_oe,
  output logic [NCH-1:0]       samp_stb,
  output logic [2:0]           phases
);
  localparam int PER = 1 << CNT_W;

  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     step;
  logic [NCH*CNT_W-1:0] duty_vec;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  phase_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .strap_hi (strap_hi),
    .phases   (phases)
  );

  duty_balance #(.CNT_W(CNT_W), .I_W(I_W), .BAL_SH(BAL_SH)) u_bal (
    .phases   (phases),
    .duty_cmd (duty_cmd),
    .isense   (isense),
    .duty_vec (duty_vec)
  );

  always_comb begin
    case (phases)
      3'd2:    step = CNT_W'(PER / 2);
      3'd3:    step = CNT_W'(PER / 3);
      default: step = CNT_W'(PER / 4);
    endcase
  end

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    logic [CNT_W+1:0] start_w;
    assign start_w = (CNT_W+2)'(k) * {2'b00, step};

    pwm_lane #(.CNT_W(CNT_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .cnt    (cnt),
      .start  (start_w[CNT_W-1:0]),
      .duty   (duty_vec[k*CNT_W +: CNT_W]),
      .active (drive_en && (k < int'(phases))),
      .pwm    (pwm_o[k]),
      .oe     (pwm_oe[k]),
      .stb    (samp_stb[k])
    );
  end
endmodule

// File: rtl/ilv_pwm_checks.sv
module ilv_pwm_checks (
  input logic       clk,
  input logic       rst,
  input logic       drive_en,
  input logic [3:0] pwm_o,
  input logic [3:0] pwm_oe,
  input logic [3:0] samp_stb,
  input logic [2:0] phases
);
  p_disable_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !drive_en |=> (pwm_oe == 4'd0 && pwm_o == 4'd0 && samp_stb == 4'd0));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phases != 3'd0) |=> $stable(phases));

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (phases == 3'd0 || phases == 3'd2 || phases == 3'd3 || phases == 3'd4));

  p_active_count_r5: assert property (@(posedge clk) disable iff (rst)
    (drive_en && phases != 3'd0) |=> ($countones(pwm_oe) == int'($past(phases))));
endmodule

bind ilv_pwm ilv_pwm_checks u_chk (
  .clk      (clk),
  .rst      (rst),
  .drive_en (drive_en),
  .pwm_o    (pwm_o),
  .pwm_oe   (pwm_oe),
  .samp_stb (samp_stb),
  .phases   (phases)
);

// File: tb/ilv_pwm_test.sv
module ilv_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int I_W   = 10;
  localparam int SH    = 2;
  localparam int P     = 1 << CNT_W;

  logic             clk = 0;
  logic             rst = 1;
  logic [1:0]       strap_hi = 2'b00;
  logic [CNT_W-1:0] duty_cmd = '0;
  logic [4*I_W-1:0] isense = '0;
  logic             drive_en = 1;
  logic [3:0]       pwm_o, pwm_oe, samp_stb;
  logic [2:0]       phases;

  int checks = 0;
  int errors = 0;

  ilv_pwm #(.CNT_W(CNT_W), .I_W(I_W), .BAL_SH(SH)) uut (
    .clk(clk), .rst(rst), .strap_hi(strap_hi), .duty_cmd(duty_cmd),
    .isense(isense), .drive_en(drive_en), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
    .samp_stb(samp_stb), .phases(phases)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  int m_cnt, m_n;
  logic [3:0] e_pwm, e_oe, e_stb;

  function automatic int dec_strap(input logic [1:0] s);
    if (s == 2'b11) return 2;
    if (s == 2'b10) return 3;
    return 4;
  endfunction

  function automatic int cur(input int k);
    return int'(isense[k*I_W +: I_W]);
  endfunction

  function automatic int model_duty(input int k, input int n);
    int sum = 0;
    int avg, d, off;
    for (int j = 0; j < n; j++) sum += cur(j);
    avg = sum / n;
    off = (cur(k) - avg) >>> SH;
    d = int'(duty_cmd) - off;
    if (d < 0) d = 0;
    if (d > P - 1) d = P - 1;
    return d;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_n = 0; e_pwm = 0; e_oe = 0; e_stb = 0;
    end else begin
      if (m_n == 0) begin
        m_n = dec_strap(strap_hi);
        e_pwm = 0; e_oe = 0; e_stb = 0;
      end else begin
        for (int k = 0; k < 4; k++) begin
          int start, lc, d;
          bit act;
          act = drive_en && (k < m_n);
          start = (k * (P / m_n)) % P;
          lc = (m_cnt - start + P) % P;
          d = model_duty(k, m_n);
          e_oe[k]  = act;
          e_pwm[k] = act && (lc < d);
          e_stb[k] = act && (lc == (d + P / 3) % P);
        end
      end
      m_cnt = (m_cnt + 1) % P;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(phases == 3'(m_n), "R2 phases", int'(phases), m_n);
      check(pwm_oe == e_oe, "R5/R9 pwm_oe", int'(pwm_oe), int'(e_oe));
      check(pwm_o == e_pwm, "R4 pwm_o", int'(pwm_o), int'(e_pwm));
      check(samp_stb == e_stb, "R8 samp_stb", int'(samp_stb), int'(e_stb));
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_cur(input int a, input int b, input int c, input int d);
    isense = {I_W'(d), I_W'(c), I_W'(b), I_W'(a)};
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk); #1;
    rst = 1; strap_hi = s;
    repeat (3) @(negedge clk);
    check(pwm_o == 0 && pwm_oe == 0 && samp_stb == 0, "R1 outputs in reset",
          int'({pwm_o, pwm_oe, samp_stb}), 0);
    check(phases == 0, "R1 phases in reset", int'(phases), 0);
    #1 rst = 0;
    @(negedge clk);
    check(pwm_oe == 0, "R2 lanes off on latch edge", int'(pwm_oe), 0);
    repeat (2) @(negedge clk);
  endtask

  // width and strobe count of channel k over one full period
  task automatic measure(input int k, input int n, input string req);
    int hi = 0;
    int st = 0;
    int ew, es;
    ew = (k < n && drive_en) ? model_duty(k, n) : 0;
    es = (k < n && drive_en) ? 1 : 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      hi += int'(pwm_o[k]);
      st += int'(samp_stb[k]);
    end
    check(hi == ew, req, hi, ew);
    check(st == es, "R8 strobe count", st, es);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    duty_cmd = 8'd64;
    set_cur(100, 100, 100, 100);
    do_reset(2'b00);
    check(phases == 3'd4, "R2 four phases", int'(phases), 4);
    for (int k = 0; k < 4; k++) measure(k, 4, "R4 equal-current width");

    settle(); set_cur(200, 100, 100, 100);
    repeat (2) @(negedge clk);
    measure(0, 4, "R6 heavy channel narrowed");
    measure(1, 4, "R6 light channel widened");

    settle(); duty_cmd = 8'd250; set_cur(0, 400, 400, 400);
    repeat (2) @(negedge clk);
    measure(0, 4, "R7 saturate high");
    settle(); duty_cmd = 8'd5;
    repeat (2) @(negedge clk);
    measure(1, 4, "R7 saturate low");

    settle(); strap_hi = 2'b11; duty_cmd = 8'd90; set_cur(50, 60, 70, 80);
    repeat (4) @(negedge clk);
    check(phases == 3'd4, "R3 strap ignored after latch", int'(phases), 4);
    measure(3, 4, "R3 channel 3 still active");

    settle(); drive_en = 0;
    repeat (2) @(negedge clk);
    check(pwm_oe == 0 && pwm_o == 0 && samp_stb == 0, "R9 disabled outputs",
          int'({pwm_o, pwm_oe, samp_stb}), 0);
    measure(0, 4, "R9 no pulses while disabled");
    settle(); drive_en = 1;

    duty_cmd = 8'd100; set_cur(300, 280, 320, 0);
    do_reset(2'b10);
    check(phases == 3'd3, "R2 three phases", int'(phases), 3);
    for (int k = 0; k < 4; k++) measure(k, 3, "R5 three-phase widths");
    settle(); set_cur(300, 280, 320, 1000);
    repeat (2) @(negedge clk);
    measure(0, 3, "R6 inactive current ignored");

    duty_cmd = 8'd40; set_cur(120, 80, 0, 0);
    do_reset(2'b11);
    check(phases == 3'd2, "R2 two phases", int'(phases), 2);
    for (int k = 0; k < 4; k++) measure(k, 2, "R4 two-phase widths");

    do_reset(2'b01);
    check(phases == 3'd4, "R2 code 01 gives four", int'(phases), 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule